// File: doc/BRIEF.md
# Four-Strike Watchdog with Paired Interval Timers

The block is a memory-mapped watchdog that counts the ticks of one of several interval timers built in beside it. Each timer divides a one-microsecond strobe down to a programmed interval. It can run once or reload itself. The watchdog counts the ticks of the timer it selects, starting from an 8-bit period. Each time that countdown runs out, a 2-bit strike counter advances and the countdown starts again from the period. The fourth strike ends the run. It can raise a reset request, which then stays high until the block itself is reset.

Software arms the watchdog with a start command. It repeats the same command as a keep-alive, which clears the strikes and reloads the countdown. A stop command only takes effect if the key value has just been written to the unlock register. Any command write uses up that key. A status register shows the live countdown and the strike count, so software can work out the time left as (3 − strikes) × period + countdown timer ticks. The microsecond strobe comes from outside the block, and the reset request goes out to an external reset controller.

Top module: `expiry_watchdog`

## Requirements
- R1: After reset, every register reads zero, the watchdog is stopped, and both the reset request and the interrupt are low.
- R2: Timer n is at byte address 0x10+4n. Bit 31 enables it, bit 30 selects reload, and bits [23:0] hold the interval P. While enabled, the timer gives one tick every P strobes (P ≥ 1). Without reload it gives one tick and then clears bit 31. Writing zero stops it.
- R3: The config register (0x0) holds the timer select in [3:0], the period in [11:4], the interrupt enable in bit 12 and the reset enable in bit 15, and it reads back unchanged. A period of 0 is stored as 1.
- R4: Writing 1 to command bit 0 (0x8) loads the countdown from the period and clears the strikes. Each tick from the selected timer then lowers the countdown by one. Status (0x4) shows the countdown in [11:4] and the strikes in [13:12].
- R5: A tick that arrives when the countdown is 1 is a strike. If there have been fewer than three strikes, the strike count goes up by one and the countdown reloads from the period.
- R6: The fourth strike stops the watchdog and leaves the countdown at 0 and the strikes at 3. If reset enable is set, the reset request goes high the cycle after and stays high until the block is reset.
- R7: When interrupt enable is set, each strike gives a one-cycle interrupt pulse in the following cycle. When it is clear, no pulse is given.
- R8: A start command while running (ping) clears the strikes and reloads the countdown from the period.
- R9: A stop (command bit 1) halts counting only if the last write to the unlock register (0xC) was 0x0000C45A and no command write has come since. Every command write uses up the key, a write of any other value clears it, and a stop without the key is ignored.
- R10: Only ticks from the timer that the config select names are counted. A select of a timer that does not exist gives no ticks.
- R11: From a start with period P, exactly 4P selected ticks bring the reset request up, and at every step the time left computed from status matches the number of ticks still to come.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle strobe at the fixed one-microsecond rate |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address. Word accesses only; bits [1:0] must be zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wd_irq | output | 1 | One-cycle pulse per strike |
| wd_reset_req | output | 1 | Held system reset request |

## Verification
A countdown or strike count that goes wrong shows up in the time-left figure read from status straight after the tick that caused it. The sweep compares that figure with the number of ticks still to come after every tick, for a range of periods up to 255. A timer that ticks at the wrong rate, or the wrong timer being selected, shows up as the countdown moving one strobe early or late, or not moving at all. A key that is wrongly kept or lost shows up within one strobe, as a countdown that keeps moving after a stop or freezes when it should not.

// File: rtl/expiry_watchdog_pkg.sv
package expiry_watchdog_pkg;

    localparam int WORD_CFG    = 0;
    localparam int WORD_STATUS = 1;
    localparam int WORD_CMD    = 2;
    localparam int WORD_UNLOCK = 3;
    localparam int WORD_TMR0   = 4;

    localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;
    localparam int          STRIKE_MAX = 3;

    typedef struct packed {
        logic       rst_en;
        logic       irq_en;
        logic [7:0] period;
        logic [3:0] sel;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer #(
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick,
    input  logic          wr_en,
    input  logic          wr_enable,
    input  logic          wr_reload,
    input  logic [PW-1:0] wr_interval,
    output logic          tick,
    output logic [31:0]   rd_word
);

    localparam int PADW = 30 - PW;

    typedef struct packed {
        logic          en;
        logic          reload;
        logic [PW-1:0] interval;
        logic [PW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_q, st_d;
    logic       fire;

    always_comb begin
        fire = st_q.en && us_tick && (st_q.cnt <= PW'(1));
        st_d = st_q;
        if (wr_en) begin
            st_d.en       = wr_enable;
            st_d.reload   = wr_reload;
            st_d.interval = wr_interval;
            st_d.cnt      = wr_interval;
        end else if (fire) begin
            if (st_q.reload) begin
                st_d.cnt = st_q.interval;
            end else begin
                st_d.en  = 1'b0;
                st_d.cnt = '0;
            end
        end else if (st_q.en && us_tick) begin
            st_d.cnt = st_q.cnt - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick    = fire && !wr_en;
    assign rd_word = {st_q.en, st_q.reload, {PADW{1'b0}}, st_q.interval};

endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
    import expiry_watchdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cmd_wr,
    input  logic        unl_wr,
    input  logic [31:0] wdata,
    output wd_cfg_t     cfg,
    output logic        unlocked,
    output logic        start_cmd,
    output logic        stop_cmd
);

    typedef struct packed {
        wd_cfg_t cfg;
        logic    key_ok;
    } reg_state_t;

    reg_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        start_cmd = 1'b0;
        stop_cmd  = 1'b0;
        if (cfg_wr) begin
            st_d.cfg.sel    = wdata[3:0];
            st_d.cfg.period = (wdata[11:4] == 8'd0) ? 8'd1 : wdata[11:4];
            st_d.cfg.irq_en = wdata[12];
            st_d.cfg.rst_en = wdata[15];
        end
        if (unl_wr) begin
            st_d.key_ok = (wdata == UNLOCK_KEY);
        end
        if (cmd_wr) begin
            start_cmd   = wdata[0];
            stop_cmd    = wdata[1] && st_q.key_ok;
            st_d.key_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign unlocked = st_q.key_ok;

endmodule

// File: rtl/wdog_strike_core.sv
module wdog_strike_core
    import expiry_watchdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start_cmd,
    input  logic       stop_cmd,
    input  logic [7:0] period,
    input  logic       irq_en,
    input  logic       rst_en,
    output logic [7:0] count,
    output logic [1:0] strikes,
    output logic       running,
    output logic       irq,
    output logic       reset_req
);

    typedef struct packed {
        logic       run;
        logic [7:0] cnt;
        logic [1:0] exp;
        logic       irq;
        logic       rst;
    } core_state_t;

    core_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (stop_cmd) begin
            st_d.run = 1'b0;
        end else if (start_cmd) begin
            st_d.run = 1'b1;
            st_d.cnt = period;
            st_d.exp = 2'd0;
        end else if (st_q.run && tick) begin
            if (st_q.cnt <= 8'd1) begin
                st_d.irq = irq_en;
                if (st_q.exp == 2'(STRIKE_MAX)) begin
                    st_d.run = 1'b0;
                    st_d.cnt = 8'd0;
                    st_d.rst = st_q.rst || rst_en;
                end else begin
                    st_d.exp = st_q.exp + 2'd1;
                    st_d.cnt = period;
                end
            end else begin
                st_d.cnt = st_q.cnt - 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count     = st_q.cnt;
    assign strikes   = st_q.exp;
    assign running   = st_q.run;
    assign irq       = st_q.irq;
    assign reset_req = st_q.rst;

endmodule

// File: rtl/expiry_watchdog.sv
module expiry_watchdog
    import expiry_watchdog_pkg::*;
#(
    parameter int NTMR   = 2,
    parameter int PW     = 24,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wd_irq,
    output logic              wd_reset_req
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              cfg_wr, cmd_wr, unl_wr;
    wd_cfg_t           cfg;
    logic              unlocked;
    logic              start_cmd, stop_cmd;
    logic [NTMR-1:0]   tmr_tick;
    logic [31:0]       tmr_rd [NTMR];
    logic              sel_tick;
    logic [7:0]        wd_count;
    logic [1:0]        wd_strikes;
    logic              wd_running;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign cfg_wr  = bus_wr_en && aligned && (int'(widx) == WORD_CFG);
    assign cmd_wr  = bus_wr_en && aligned && (int'(widx) == WORD_CMD);
    assign unl_wr  = bus_wr_en && aligned && (int'(widx) == WORD_UNLOCK);

    wdog_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cmd_wr    (cmd_wr),
        .unl_wr    (unl_wr),
        .wdata     (bus_wdata),
        .cfg       (cfg),
        .unlocked  (unlocked),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd)
    );

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        logic tmr_wr;
        assign tmr_wr = bus_wr_en && aligned && (int'(widx) == WORD_TMR0 + g);
        wdog_interval_timer #(.PW(PW)) u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .us_tick     (us_tick),
            .wr_en       (tmr_wr),
            .wr_enable   (bus_wdata[31]),
            .wr_reload   (bus_wdata[30]),
            .wr_interval (bus_wdata[PW-1:0]),
            .tick        (tmr_tick[g]),
            .rd_word     (tmr_rd[g])
        );
    end

    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NTMR; i++) begin
            if (int'(cfg.sel) == i) begin
                sel_tick = tmr_tick[i];
            end
        end
    end

    wdog_strike_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sel_tick),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .period    (cfg.period),
        .irq_en    (cfg.irq_en),
        .rst_en    (cfg.rst_en),
        .count     (wd_count),
        .strikes   (wd_strikes),
        .running   (wd_running),
        .irq       (wd_irq),
        .reset_req (wd_reset_req)
    );

    always_comb begin
        bus_rdata = 32'd0;
        if (aligned) begin
            if (int'(widx) == WORD_CFG) begin
                bus_rdata = {16'd0, cfg.rst_en, 2'b00, cfg.irq_en, cfg.period, cfg.sel};
            end else if (int'(widx) == WORD_STATUS) begin
                bus_rdata = {18'd0, wd_strikes, wd_count, 4'd0};
            end
            for (int i = 0; i < NTMR; i++) begin
                if (int'(widx) == WORD_TMR0 + i) begin
                    bus_rdata = tmr_rd[i];
                end
            end
        end
    end

endmodule

// File: rtl/expiry_watchdog_chk.sv
module expiry_watchdog_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              wd_irq,
    input logic              wd_reset_req,
    input logic              irq_en,
    input logic [1:0]        strikes,
    input logic              running,
    input logic              unlocked
);

    logic cmd_write;
    assign cmd_write = bus_wr_en && (bus_addr == ADDR_W'(8));

    // R6: once raised, the reset request stays up
    assert_reset_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |=> wd_reset_req);

    // R6: the request only rises on the fourth strike
    assert_reset_on_fourth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset_req) |-> (strikes == 2'd3));

    // R7: interrupt pulses need the enable
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> $past(irq_en));

    // R9: any command write uses up the key
    assert_key_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_write |=> !unlocked);

    // R9: keyed stop halts the watchdog
    assert_keyed_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && bus_wdata[1] && unlocked) |=> !running);

    // R9: stop without key leaves a run going
    assert_locked_stop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && bus_wdata[1] && !unlocked && running && strikes != 2'd3)
        |=> running);

endmodule

bind expiry_watchdog expiry_watchdog_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .wd_irq       (wd_irq),
    .wd_reset_req (wd_reset_req),
    .irq_en       (cfg.irq_en),
    .strikes      (wd_strikes),
    .running      (wd_running),
    .unlocked     (unlocked)
);

// File: tb/expiry_watchdog_test.sv
`timescale 1ns/1ps
module expiry_watchdog_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_irq;
    logic        wd_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    expiry_watchdog uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .us_tick      (us_tick),
        .bus_wr_en    (bus_wr_en),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wd_irq       (wd_irq),
        .wd_reset_req (wd_reset_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = 6'(a);
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 6'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    endtask

    task automatic status(output int cnt, output int ex);
        logic [31:0] v;
        rd(4, v);
        cnt = int'(v[11:4]);
        ex  = int'(v[13:12]);
    endtask

    function automatic logic [31:0] cfgw(int sel, int per, bit ie, bit re);
        return (32'(re) << 15) | (32'(ie) << 12) | (32'(per & 255) << 4) | 32'(sel & 15);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int c, e, rem;

        // R1 reset state
        do_reset();
        for (int a = 0; a < 24; a += 4) begin
            rd(a, v);
            chk("R1 reg reads zero", int'(v), 0);
        end
        chk("R1 reset_req low", int'(wd_reset_req), 0);
        chk("R1 irq low", int'(wd_irq), 0);

        // R3 config readback and clamp
        wr(0, cfgw(1, 77, 1, 1));
        rd(0, v);
        chk("R3 cfg readback", int'(v), int'(cfgw(1, 77, 1, 1)));
        wr(0, cfgw(0, 0, 0, 0));
        rd(0, v);
        chk("R3 period zero stored as one", int'(v[11:4]), 1);

        // R11 / R4 / R5 / R6 sweep over periods
        for (int p = 1; p <= 13; p++) begin
            int per;
            per = (p == 13) ? 255 : p;
            do_reset();
            wr(16, 32'hC000_0001);
            wr(0, cfgw(0, per, 0, 1));
            wr(8, 32'h1);
            status(c, e);
            chk("R4 start loads period", c, per);
            chk("R4 start clears strikes", e, 0);
            for (int t = 1; t <= 4 * per; t++) begin
                pulse(1);
                status(c, e);
                rem = (3 - e) * per + c;
                chk("R11 time left", rem, 4 * per - t);
                if (t < 4 * per) chk("R11 no early reset", int'(wd_reset_req), 0);
            end
            chk("R6 reset after 4P", int'(wd_reset_req), 1);
            chk("R6 count zero", c, 0);
            chk("R6 strikes three", e, 3);
            pulse(2);
            status(c, e);
            chk("R6 stopped after fourth", c, 0);
            chk("R6 reset held", int'(wd_reset_req), 1);
        end

        // R5 reload detail, R7 irq pulse
        do_reset();
        wr(16, 32'hC000_0001);
        wr(0, cfgw(0, 3, 1, 0));
        wr(8, 32'h1);
        pulse(2);
        status(c, e);
        chk("R5 count before strike", c, 1);
        chk("R7 no irq mid count", int'(wd_irq), 0);
        pulse(1);
        chk("R7 irq pulse on strike", int'(wd_irq), 1);
        status(c, e);
        chk("R5 reload to period", c, 3);
        chk("R5 strike counted", e, 1);
        @(negedge clk);
        chk("R7 irq one cycle", int'(wd_irq), 0);

        // R8 ping
        pulse(4);
        status(c, e);
        chk("R8 pre-ping strikes", e, 2);
        wr(8, 32'h1);
        status(c, e);
        chk("R8 ping clears strikes", e, 0);
        chk("R8 ping reloads", c, 3);

        // R7 irq disabled, R6 reset disabled
        wr(0, cfgw(0, 1, 0, 0));
        wr(8, 32'h1);
        for (int t = 0; t < 4; t++) begin
            pulse(1);
            chk("R7 irq off no pulse", int'(wd_irq), 0);
        end
        status(c, e);
        chk("R6 fourth strike count", c, 0);
        chk("R6 no reset when disabled", int'(wd_reset_req), 0);

        // R9 stop without key is ignored
        wr(0, cfgw(0, 9, 0, 0));
        wr(8, 32'h1);
        wr(8, 32'h2);
        pulse(1);
        status(c, e);
        chk("R9 locked stop ignored", c, 8);
        // R9 keyed stop
        wr(12, 32'h0000_C45A);
        wr(8, 32'h2);
        pulse(3);
        status(c, e);
        chk("R9 keyed stop freezes", c, 8);
        // R9 key used up by a command write
        wr(8, 32'h1);
        wr(12, 32'h0000_C45A);
        wr(8, 32'h0);
        wr(8, 32'h2);
        pulse(1);
        status(c, e);
        chk("R9 key consumed", c, 8);
        // R9 wrong value clears the key
        wr(12, 32'h0000_C45A);
        wr(12, 32'h0000_1234);
        wr(8, 32'h2);
        pulse(1);
        status(c, e);
        chk("R9 wrong key clears", c, 7);

        // R2 interval timer rate
        do_reset();
        wr(16, 32'hC000_0003);
        rd(16, v);
        chk("R2 timer readback", int'(v), int'(32'hC000_0003));
        wr(0, cfgw(0, 5, 0, 0));
        wr(8, 32'h1);
        pulse(2);
        status(c, e);
        chk("R2 no tick before P strobes", c, 5);
        pulse(1);
        status(c, e);
        chk("R2 tick at P strobes", c, 4);
        pulse(3);
        status(c, e);
        chk("R2 reload period", c, 3);
        // R2 one shot
        wr(16, 32'h8000_0002);
        pulse(2);
        status(c, e);
        chk("R2 one-shot tick", c, 2);
        rd(16, v);
        chk("R2 one-shot clears enable", int'(v[31]), 0);
        pulse(4);
        status(c, e);
        chk("R2 one-shot no more ticks", c, 2);
        // R2 write zero stops
        wr(16, 32'hC000_0001);
        pulse(1);
        wr(16, 32'h0);
        pulse(3);
        status(c, e);
        chk("R2 zero write stops timer", c, 1);

        // R10 selection
        wr(0, cfgw(1, 6, 0, 0));
        wr(8, 32'h1);
        wr(16, 32'hC000_0001);
        pulse(3);
        status(c, e);
        chk("R10 other timer ignored", c, 6);
        wr(20, 32'hC000_0002);
        pulse(4);
        status(c, e);
        chk("R10 selected timer counts", c, 4);
        wr(0, cfgw(7, 6, 0, 0));
        wr(8, 32'h1);
        pulse(4);
        status(c, e);
        chk("R10 missing timer no ticks", c, 6);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule